// File: doc/BRIEF.md
# Watchdog Timer with Start-up Hold-off

This block is a supervisory timer that counts enable pulses from a 32.768 kHz time base. Software programs one 8-bit control register through a single-address write/read port. Once enabled, the timer counts toward a selectable period, and a kick strobe from the supervised logic sends the count back to zero. If the period runs out, the hardware latches a timeout flag in the register and drives an active-high output pulse of selectable length. It then stays halted until software writes the flag back to zero.

An optional hold-off of 2,097,152 ticks (64 seconds) can come before each count sequence. A supply-present input clears the enable bit when power is lost, and the bit is not restored when power returns. Every duration is counted in ticks of the time-base enable, never in system clocks. The hold-off length and the two pulse widths are parameters.

Top module: `watchdog_unit`

## Requirements
- R1: After reset the control register reads 0x00 and `wdOut` is low.
- R2: A write with `regWrEn` high loads all 8 bits, and `regRdData` always returns the register. The bit layout is: 7 enable, 6 timeout flag, 5 hold-off select, 4 pulse-width select, 3 reserved, 2..0 period select. A kick never changes any register bit.
- R3: A sequence starts on the cycle after enable becomes 1 with the flag at 0, or after the flag is written to 0 while enable is 1. Without hold-off, the timeout happens on the P-th tick after the start. For period codes 000..111, P is 32, 512, 2048, 4096, 32768, 524288, 1048576 and 2097152 ticks.
- R4: On timeout, bit 6 becomes 1 and `wdOut` goes high on the same cycle. `wdOut` stays high for exactly 4 ticks when bit 4 is 0, or 4096 ticks when bit 4 is 1.
- R5: While bit 6 is 1, no counting happens and no new pulse is produced. Writing bit 6 to 0 while enabled restarts a full period.
- R6: With bit 5 set, a hold-off of DELAY_TICKS ticks (default 2,097,152) comes before the period count begins.
- R7: A kick during the period count sets the count to zero. It then takes a full P ticks from the kick edge to reach timeout. A kick on the very tick that would expire the period wins over the expiry. A kick during the hold-off is ignored.
- R8: While `supplyOk` is low, hardware clears bit 7 and counting stops. The bit stays 0 after the supply returns.
- R9: Bit 3 is stored and read back, but it has no effect on the period.
- R10: The period count and the pulse length advance only on cycles with `tickEn` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | One-cycle enable per 32.768 kHz time-base tick |
| supplyOk | input | 1 | High while main supply is present |
| kick | input | 1 | Restart strobe from supervised logic |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write value |
| regRdData | output | 8 | Control register contents |
| wdOut | output | 1 | Active-high watchdog pulse |

## Verification
The kick and the period expiry can fall on the same clock edge. The bench provokes this by timing a kick onto the exact tick that would end a 32-tick period. It then judges the result by checking that no pulse appears at the natural expiry time, and that a pulse appears exactly 32 ticks after the kick. A scoreboard predicts the start cycle and width of every pulse, so any early, late or extra pulse is reported.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_COUNT = 2'd2,
    ST_HALT  = 2'd3
  } wdtState_t;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic setFlag;
    logic firePulse;
  } wdtStrobes_t;

  typedef struct packed {
    logic       enBit;
    logic       flagBit;
    logic       holdBit;
    logic       pulseSel;
    logic       rsvdBit;
    logic [2:0] periodSel;
  } wdtCfg_t;

  // period length in ticks: a power of two picked by the select code
  function automatic int unsigned periodTicks(input logic [2:0] code);
    int unsigned expo;
    case (code)
      3'd0: expo = 5;
      3'd1: expo = 9;
      3'd2: expo = 11;
      3'd3: expo = 12;
      3'd4: expo = 15;
      3'd5: expo = 19;
      3'd6: expo = 20;
      default: expo = 21;
    endcase
    return 32'd1 << expo;
  endfunction

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W       = 22,
  parameter int unsigned PULSE_W     = 13,
  parameter int unsigned DELAY_TICKS = 2097152,
  parameter int unsigned SHORT_PULSE = 4,
  parameter int unsigned LONG_PULSE  = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tickEn,
  input  logic        supplyOk,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  input  wdtStrobes_t strb,
  output wdtCfg_t     cfg,
  output logic        hitPeriod,
  output logic        hitDelay,
  output logic        wdOut
);

  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cntNext;
  logic [CNT_W-1:0]   periodLimit;
  logic [PULSE_W-1:0] pulseLeft;

  assign cntNext     = cnt + CNT_W'(1);
  assign periodLimit = CNT_W'(periodTicks(cfg.periodSel));
  assign hitPeriod   = (cntNext == periodLimit);
  assign hitDelay    = (cntNext == CNT_W'(DELAY_TICKS));

  // control register: write first, hardware flag set next, supply loss last
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else begin
      if (regWrEn) cfg <= wdtCfg_t'(regWrData);
      if (strb.setFlag) cfg.flagBit <= 1'b1;
      if (!supplyOk) cfg.enBit <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (strb.clrCnt) begin
      cnt <= '0;
    end else if (strb.incCnt) begin
      cnt <= cntNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulseLeft <= '0;
    end else if (strb.firePulse) begin
      pulseLeft <= cfg.pulseSel ? PULSE_W'(LONG_PULSE) : PULSE_W'(SHORT_PULSE);
    end else if (tickEn && pulseLeft != '0) begin
      pulseLeft <= pulseLeft - PULSE_W'(1);
    end
  end

  assign wdOut = (pulseLeft != '0);

  assert_flag_with_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(wdOut) |-> cfg.flagBit);

  assert_supply_clears_en_R8: assert property (@(posedge clk) disable iff (rst)
    !supplyOk |=> !cfg.enBit);

  assert_fire_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
    strb.firePulse |=> (cfg.flagBit && wdOut));

endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tickEn,
  input  logic        kick,
  input  wdtCfg_t     cfg,
  input  logic        hitPeriod,
  input  logic        hitDelay,
  output wdtStrobes_t strb
);

  wdtState_t state;
  wdtState_t stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    if (!cfg.enBit) begin
      stateNext = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE, ST_HALT: begin
          if (!cfg.flagBit) begin
            strb.clrCnt = 1'b1;
            stateNext   = cfg.holdBit ? ST_HOLD : ST_COUNT;
          end else begin
            stateNext = ST_HALT;
          end
        end
        ST_HOLD: begin
          if (cfg.flagBit) begin
            stateNext = ST_HALT;
          end else if (tickEn) begin
            if (hitDelay) begin
              strb.clrCnt = 1'b1;
              stateNext   = ST_COUNT;
            end else begin
              strb.incCnt = 1'b1;
            end
          end
        end
        default: begin
          if (cfg.flagBit) begin
            stateNext = ST_HALT;
          end else if (kick) begin
            strb.clrCnt = 1'b1;
          end else if (tickEn) begin
            if (hitPeriod) begin
              strb.setFlag   = 1'b1;
              strb.firePulse = 1'b1;
              stateNext      = ST_HALT;
            end else begin
              strb.incCnt = 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assert_kick_beats_expiry_R7: assert property (@(posedge clk) disable iff (rst)
    (kick && state == ST_COUNT) |-> !strb.setFlag);

  assert_halt_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT && cfg.flagBit) |-> !(strb.firePulse || strb.incCnt));

  assert_idle_no_count_R8: assert property (@(posedge clk) disable iff (rst)
    !cfg.enBit |=> state == ST_IDLE);

  assert_hold_ignores_kick_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && kick && !tickEn) |-> !strb.clrCnt);

endmodule

// File: rtl/watchdog_unit.sv
module watchdog_unit
  import wdt_pkg::*;
#(
  parameter int unsigned DELAY_TICKS = 2097152,
  parameter int unsigned SHORT_PULSE = 4,
  parameter int unsigned LONG_PULSE  = 4096
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tickEn,
  input  logic       supplyOk,
  input  logic       kick,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       wdOut
);

  localparam int unsigned MAX_PERIOD = 2097152;
  localparam int unsigned CNT_W   = $clog2((DELAY_TICKS > MAX_PERIOD ? DELAY_TICKS : MAX_PERIOD) + 1);
  localparam int unsigned PULSE_W = $clog2((LONG_PULSE > SHORT_PULSE ? LONG_PULSE : SHORT_PULSE) + 1);

  wdtStrobes_t strb;
  wdtCfg_t     cfg;
  logic        hitPeriod;
  logic        hitDelay;

  wdt_control uCtrl (
    .clk      (clk),
    .rst      (rst),
    .tickEn   (tickEn),
    .kick     (kick),
    .cfg      (cfg),
    .hitPeriod(hitPeriod),
    .hitDelay (hitDelay),
    .strb     (strb)
  );

  wdt_datapath #(
    .CNT_W      (CNT_W),
    .PULSE_W    (PULSE_W),
    .DELAY_TICKS(DELAY_TICKS),
    .SHORT_PULSE(SHORT_PULSE),
    .LONG_PULSE (LONG_PULSE)
  ) uData (
    .clk      (clk),
    .rst      (rst),
    .tickEn   (tickEn),
    .supplyOk (supplyOk),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .strb     (strb),
    .cfg      (cfg),
    .hitPeriod(hitPeriod),
    .hitDelay (hitDelay),
    .wdOut    (wdOut)
  );

  assign regRdData = cfg;

endmodule

// File: tb/watchdog_unit_test.sv
module watchdog_unit_test;

  localparam int HOLD = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickEn = 1'b1;
  logic       supplyOk = 1'b1;
  logic       kick = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       wdOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wrEdge = 0;
  bit finished = 1'b0;

  typedef struct {
    int    start;
    int    width;
    string tag;
  } pulseExp_t;
  pulseExp_t expQ[$];

  always #4 clk = ~clk;

  watchdog_unit #(.DELAY_TICKS(HOLD)) uut (
    .clk(clk), .rst(rst), .tickEn(tickEn), .supplyOk(supplyOk), .kick(kick),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData), .wdOut(wdOut)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int benchPeriod(input int code);
    case (code)
      0: return 32;
      1: return 512;
      2: return 2048;
      3: return 4096;
      default: return 32768;
    endcase
  endfunction

  // monitor: measure every pulse and compare with the scoreboard
  logic prevOut = 1'b0;
  int   pulseStart = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (wdOut && !prevOut) pulseStart = cyc;
      if (!wdOut && prevOut) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL unexpected pulse R5: start=%0d width=%0d expected none", pulseStart, cyc - pulseStart);
        end else begin
          pulseExp_t e;
          e = expQ.pop_front();
          if (e.start != pulseStart || e.width != cyc - pulseStart) begin
            errors++;
            $display("FAIL %s: start=%0d width=%0d expected start=%0d width=%0d",
                     e.tag, pulseStart, cyc - pulseStart, e.start, e.width);
          end
        end
      end
      prevOut = wdOut;
    end
  end

  task automatic pushPulse(input int start, input int width, input string tag);
    pulseExp_t e;
    e.start = start; e.width = width; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic regWrite(input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d;
    @(posedge clk); #1;
    wrEdge = cyc;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic checkReg(input logic [7:0] exp, input string tag);
    @(negedge clk);
    checks++;
    if (regRdData !== exp) begin
      errors++;
      $display("FAIL %s: reg=%02h expected %02h", tag, regRdData, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runPeriod(input logic [7:0] cfgVal, input int width, input string tag);
    int p;
    p = benchPeriod(int'(cfgVal[2:0]));
    regWrite(8'h00);
    regWrite(cfgVal);
    pushPulse(wrEdge + p + 1, width, tag);
    waitCycles(p + width + 20);
  endtask

  initial begin
    int kEdge;
    int xEdge;
    waitCycles(3);
    rst = 1'b0;
    // R1 reset state
    @(negedge clk);
    checks++;
    if (wdOut !== 1'b0) begin errors++; $display("FAIL R1: wdOut=%b expected 0", wdOut); end
    checkReg(8'h00, "R1 reset register");

    // R2 and R9: all bits including the reserved one read back
    regWrite(8'h3A);
    checkReg(8'h3A, "R2 R9 readback");

    // R3 R4 shortest period, short pulse
    regWrite(8'h00);
    regWrite(8'h80);
    pushPulse(wrEdge + 33, 4, "R3 R4 code0");
    waitCycles(60);
    checkReg(8'hC0, "R4 flag set");
    waitCycles(150);            // R5: halted, no second pulse
    checkReg(8'hC0, "R5 still halted");
    regWrite(8'h80);            // R5 clear flag restarts
    pushPulse(wrEdge + 33, 4, "R5 restart");
    waitCycles(60);

    runPeriod(8'h81, 4, "R3 code1");
    runPeriod(8'h92, 4096, "R3 R4 code2 long pulse");
    runPeriod(8'h83, 4, "R3 code3");
    runPeriod(8'h84, 4, "R3 code4");
    runPeriod(8'h88, 4, "R9 reserved bit no effect");

    // R6 hold-off, with an ignored kick inside it (R7)
    regWrite(8'h00);
    regWrite(8'hA0);
    pushPulse(wrEdge + 1 + HOLD + 32, 4, "R6 R7 hold-off");
    waitCycles(49);
    kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    waitCycles(120);
    checkReg(8'hE0, "R2 kick leaves register");

    // R7 kick in the middle of the count
    regWrite(8'h00);
    regWrite(8'h81);
    waitCycles(299);
    kick = 1'b1;
    @(posedge clk); #1; kEdge = cyc;
    @(negedge clk); kick = 1'b0;
    pushPulse(kEdge + 512, 4, "R7 mid kick");
    waitCycles(540);

    // R7 kick on the expiry tick wins
    regWrite(8'h00);
    regWrite(8'h80);
    while (cyc != wrEdge + 32) @(negedge clk);
    kick = 1'b1;
    @(posedge clk); #1; kEdge = cyc;
    @(negedge clk); kick = 1'b0;
    pushPulse(kEdge + 32, 4, "R7 kick at expiry");
    waitCycles(60);

    // R10 counting only on ticks
    regWrite(8'h00);
    tickEn = 1'b0;
    regWrite(8'h80);
    waitCycles(200);
    tickEn = 1'b1;
    xEdge = cyc + 1;
    pushPulse(xEdge + 31, 4, "R10 tick gating");
    waitCycles(60);

    // R8 supply loss
    regWrite(8'h00);
    regWrite(8'h81);
    waitCycles(100);
    supplyOk = 1'b0;
    waitCycles(5);
    checkReg(8'h01, "R8 enable cleared");
    supplyOk = 1'b1;
    waitCycles(700);
    checkReg(8'h01, "R8 enable not restored");

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R3: %0d pulses missing expected 0", expQ.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R1: run hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule